// File: doc/BRIEF.md
# GPIO Pin Owner-Core Selector

This block sits between two processor cores and a bank of GPIO pads. Each pin has an owner, either core 0 or core 1. Only the owning core's output-level and output-enable writes reach the pad. Writes from the other core are dropped without any sign. Both cores can still see every pad input level, whoever owns the pin.

Ownership is kept in a set of select registers. Each register holds eight 2-bit owner fields. A configuration write carries one strobe per field, so it can retarget any subset of a register's pins and leave the others alone. A write-protect lock guards the select registers and is closed at reset. Software opens the lock, rewrites the owners, then closes it again.

Top module: `gpio_owner_sel`

## Requirements
- R1: After reset, every owner field reads 00 (core 0), `pad_out` and `pad_oe` are all zero, and the write-protect lock is closed.
- R2: The owner of pin p is in select register p/8, bits [2*(p mod 8)+1 : 2*(p mod 8)]. Code 00 gives the pin to core 0 and code 01 gives it to core 1. `cfg_rdata` returns the register chosen by `cfg_addr` in the same cycle.
- R3: Owner codes 10 and 11 are stored as written, read back unchanged, and give the pin to core 0.
- R4: A select write (`cfg_we`) is ignored while the lock is closed. `wp_we` with `wp_close`=0 opens the lock and `wp_we` with `wp_close`=1 closes it, both from the next cycle on. A select write in the same cycle as the opening write is still ignored.
- R5: An accepted select write replaces only the 2-bit fields whose `cfg_fsel` bit is 1. The other fields of the same register, and all other registers, keep their values.
- R6: A write by the owning core with `*_out_we[p]` sets `pad_out[p]` to `*_out_val[p]` on the next cycle. A write with `*_dir_we[p]` sets `pad_oe[p]` to `*_dir_val[p]` on the next cycle. Without a write from the owner, both outputs hold their values.
- R7: Output or direction writes by the core that does not own a pin leave that pin unchanged, including when both cores write the same pin in the same cycle.
- R8: A new owner applies from the cycle after the accepted select write. A pin write in the same cycle as the owner change is judged against the old owner.
- R9: `c0_in` and `c1_in` both equal `pad_in` at all times, whatever the owners.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_we | input | 1 | Write strobe for the write-protect lock |
| wp_close | input | 1 | New lock state: 1 closes the lock, 0 opens it |
| cfg_we | input | 1 | Select-register write strobe |
| cfg_addr | input | 2 | Select-register index, used for both write and read |
| cfg_fsel | input | 8 | Per-field write strobes |
| cfg_wdata | input | 16 | Select-register write data |
| cfg_rdata | output | 16 | Contents of the select register chosen by `cfg_addr` |
| c0_out_we | input | 32 | Core 0 per-pin output-level write strobes |
| c0_out_val | input | 32 | Core 0 per-pin output levels |
| c0_dir_we | input | 32 | Core 0 per-pin output-enable write strobes |
| c0_dir_val | input | 32 | Core 0 per-pin output enables |
| c1_out_we | input | 32 | Core 1 per-pin output-level write strobes |
| c1_out_val | input | 32 | Core 1 per-pin output levels |
| c1_dir_we | input | 32 | Core 1 per-pin output-enable write strobes |
| c1_dir_val | input | 32 | Core 1 per-pin output enables |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| c0_in | output | 32 | Pad input levels as seen by core 0 |
| c1_in | output | 32 | Pad input levels as seen by core 1 |

## Verification
If an owner field is corrupted, the readback shows it one cycle after the faulty write. The pin then starts accepting the wrong core's writes from the next pin write onward, which shows on `pad_out` or `pad_oe` one cycle later. A wrong lock state shows on the first select write after it, as a readback that changed or did not change. Writes that land in the same cycle as a lock or owner change show in the readback and on the pad one cycle later.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;

    localparam int FIELD_W      = 2;
    localparam int PINS_PER_REG = 8;
    localparam int REG_W        = FIELD_W * PINS_PER_REG;

    typedef enum logic [FIELD_W-1:0] {
        OWN_CORE0 = 2'b00,
        OWN_CORE1 = 2'b01,
        OWN_RSV_A = 2'b10,
        OWN_RSV_B = 2'b11
    } owner_e;

    typedef struct packed {
        logic out_we;
        logic out_val;
        logic dir_we;
        logic dir_val;
    } pin_wr_t;

    // Only the exact core-1 code hands a pin to core 1; reserved codes fall back to core 0.
    function automatic logic owner_is_core1(input logic [FIELD_W-1:0] field);
        return owner_e'(field) == OWN_CORE1;
    endfunction

    // Expand per-field strobes to a bit mask over one select register.
    function automatic logic [REG_W-1:0] field_mask(input logic [PINS_PER_REG-1:0] fsel);
        logic [REG_W-1:0] m;
        m = '0;
        for (int j = 0; j < PINS_PER_REG; j++) begin
            m[j*FIELD_W +: FIELD_W] = {FIELD_W{fsel[j]}};
        end
        return m;
    endfunction

    // Clear the selected fields, then insert the new value into them.
    function automatic logic [REG_W-1:0] merge_fields(
        input logic [REG_W-1:0]        old_v,
        input logic [REG_W-1:0]        new_v,
        input logic [PINS_PER_REG-1:0] fsel
    );
        logic [REG_W-1:0] m;
        m = field_mask(fsel);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/gpio_own_wprot.sv
module gpio_own_wprot (
    input  logic clk,
    input  logic rst,
    input  logic wp_we,
    input  logic wp_close,
    input  logic cfg_we,
    output logic wr_open,
    output logic wr_ok
);

    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b1;
        end else if (wp_we) begin
            lock_q <= wp_close;
        end
    end

    assign wr_open = ~lock_q;
    assign wr_ok   = cfg_we & ~lock_q;

endmodule

// File: rtl/gpio_own_selreg.sv
module gpio_own_selreg
    import gpio_own_pkg::*;
#(
    parameter  int NUM_PINS = 32,
    localparam int NUM_REGS = NUM_PINS / PINS_PER_REG,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_ok,
    input  logic [IDX_W-1:0]          cfg_addr,
    input  logic [PINS_PER_REG-1:0]   cfg_fsel,
    input  logic [REG_W-1:0]          cfg_wdata,
    output logic [REG_W-1:0]          cfg_rdata,
    output logic [NUM_PINS*FIELD_W-1:0] owner_fields
);

    logic [NUM_REGS-1:0][REG_W-1:0] all_q;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [REG_W-1:0] sel_q;
        logic             hit;

        assign hit = wr_ok && (cfg_addr == IDX_W'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q <= '0;
            end else if (hit) begin
                sel_q <= merge_fields(sel_q, cfg_wdata, cfg_fsel);
            end
        end

        assign all_q[r]                           = sel_q;
        assign owner_fields[r*REG_W +: REG_W]     = sel_q;
    end

    assign cfg_rdata = all_q[cfg_addr];

endmodule

// File: rtl/gpio_own_lane.sv
module gpio_own_lane
    import gpio_own_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] owner,
    input  pin_wr_t            wr_c0,
    input  pin_wr_t            wr_c1,
    output logic               out_q,
    output logic               oe_q
);

    pin_wr_t eff;

    always_comb begin
        eff = owner_is_core1(owner) ? wr_c1 : wr_c0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            if (eff.out_we) out_q <= eff.out_val;
            if (eff.dir_we) oe_q  <= eff.dir_val;
        end
    end

endmodule

// File: rtl/gpio_owner_sel.sv
module gpio_owner_sel
    import gpio_own_pkg::*;
#(
    parameter  int NUM_PINS = 32,
    localparam int NUM_REGS = NUM_PINS / PINS_PER_REG,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wp_we,
    input  logic                    wp_close,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_addr,
    input  logic [PINS_PER_REG-1:0] cfg_fsel,
    input  logic [REG_W-1:0]        cfg_wdata,
    output logic [REG_W-1:0]        cfg_rdata,
    input  logic [NUM_PINS-1:0]     c0_out_we,
    input  logic [NUM_PINS-1:0]     c0_out_val,
    input  logic [NUM_PINS-1:0]     c0_dir_we,
    input  logic [NUM_PINS-1:0]     c0_dir_val,
    input  logic [NUM_PINS-1:0]     c1_out_we,
    input  logic [NUM_PINS-1:0]     c1_out_val,
    input  logic [NUM_PINS-1:0]     c1_dir_we,
    input  logic [NUM_PINS-1:0]     c1_dir_val,
    input  logic [NUM_PINS-1:0]     pad_in,
    output logic [NUM_PINS-1:0]     pad_out,
    output logic [NUM_PINS-1:0]     pad_oe,
    output logic [NUM_PINS-1:0]     c0_in,
    output logic [NUM_PINS-1:0]     c1_in
);

    logic                          wr_open;
    logic                          wr_ok;
    logic [NUM_PINS*FIELD_W-1:0]   owner_fields;

    gpio_own_wprot u_wprot (
        .clk      (clk),
        .rst      (rst),
        .wp_we    (wp_we),
        .wp_close (wp_close),
        .cfg_we   (cfg_we),
        .wr_open  (wr_open),
        .wr_ok    (wr_ok)
    );

    gpio_own_selreg #(.NUM_PINS(NUM_PINS)) u_selreg (
        .clk          (clk),
        .rst          (rst),
        .wr_ok        (wr_ok),
        .cfg_addr     (cfg_addr),
        .cfg_fsel     (cfg_fsel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .owner_fields (owner_fields)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_wr_t w0;
        pin_wr_t w1;

        assign w0 = '{out_we: c0_out_we[p], out_val: c0_out_val[p],
                      dir_we: c0_dir_we[p], dir_val: c0_dir_val[p]};
        assign w1 = '{out_we: c1_out_we[p], out_val: c1_out_val[p],
                      dir_we: c1_dir_we[p], dir_val: c1_dir_val[p]};

        gpio_own_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .owner (owner_fields[p*FIELD_W +: FIELD_W]),
            .wr_c0 (w0),
            .wr_c1 (w1),
            .out_q (pad_out[p]),
            .oe_q  (pad_oe[p])
        );
    end

    // Input levels are shared by both cores regardless of ownership.
    assign c0_in = pad_in;
    assign c1_in = pad_in;

endmodule

// File: rtl/gpio_owner_sel_chk.sv
module gpio_owner_sel_chk
    import gpio_own_pkg::*;
#(
    parameter  int NUM_PINS = 32,
    localparam int NUM_REGS = NUM_PINS / PINS_PER_REG,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cfg_we,
    input logic [IDX_W-1:0]            cfg_addr,
    input logic [PINS_PER_REG-1:0]     cfg_fsel,
    input logic                        wr_open,
    input logic [NUM_PINS*FIELD_W-1:0] owner_fields,
    input logic [NUM_PINS-1:0]         c0_out_we,
    input logic [NUM_PINS-1:0]         c1_out_we,
    input logic [NUM_PINS-1:0]         c1_out_val,
    input logic [NUM_PINS-1:0]         c0_dir_we,
    input logic [NUM_PINS-1:0]         c1_dir_we,
    input logic [NUM_PINS-1:0]         pad_in,
    input logic [NUM_PINS-1:0]         pad_out,
    input logic [NUM_PINS-1:0]         pad_oe,
    input logic [NUM_PINS-1:0]         c0_in,
    input logic [NUM_PINS-1:0]         c1_in
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (owner_fields == '0 && !wr_open && pad_out == '0 && pad_oe == '0));

    assert_locked_write_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !wr_open) |=> $stable(owner_fields));

    assert_inputs_shared_R9: assert property (@(posedge clk) disable iff (rst)
        (c0_in == pad_in) && (c1_in == pad_in));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int RIDX = p / PINS_PER_REG;
        localparam int FIDX = p % PINS_PER_REG;
        logic own1;

        assign own1 = owner_is_core1(owner_fields[p*FIELD_W +: FIELD_W]);

        assert_field_untouched_R5: assert property (@(posedge clk) disable iff (rst)
            !(cfg_we && wr_open && cfg_addr == IDX_W'(RIDX) && cfg_fsel[FIDX])
            |=> $stable(owner_fields[p*FIELD_W +: FIELD_W]));

        assert_owner_write_R6: assert property (@(posedge clk) disable iff (rst)
            (own1 && c1_out_we[p]) |=> (pad_out[p] == $past(c1_out_val[p])));

        assert_nonowner_out_R7: assert property (@(posedge clk) disable iff (rst)
            ((own1 && !c1_out_we[p]) || (!own1 && !c0_out_we[p])) |=> $stable(pad_out[p]));

        assert_nonowner_dir_R7: assert property (@(posedge clk) disable iff (rst)
            ((own1 && !c1_dir_we[p]) || (!own1 && !c0_dir_we[p])) |=> $stable(pad_oe[p]));
    end

endmodule

bind gpio_owner_sel gpio_owner_sel_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_owner_sel_bench.sv
module gpio_owner_sel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_we = 1'b0, wp_close = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_fsel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [31:0] c0_out_we = '0, c0_out_val = '0, c0_dir_we = '0, c0_dir_val = '0;
    logic [31:0] c1_out_we = '0, c1_out_val = '0, c1_dir_we = '0, c1_dir_val = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, c0_in, c1_in;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_owner_sel u_gpio_owner_sel (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_sel(input logic [1:0] a, input string req, input logic [15:0] exp);
        cfg_addr = a;
        #1;
        check(req, {16'h0, cfg_rdata}, {16'h0, exp});
    endtask

    task automatic sel_write(input logic [1:0] a, input logic [7:0] fs, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_fsel = fs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_fsel = '0; cfg_wdata = '0;
    endtask

    task automatic set_lock(input logic closed);
        wp_we = 1'b1; wp_close = closed;
        @(negedge clk);
        wp_we = 1'b0;
    endtask

    // core: 0 or 1; dir selects output-enable instead of output level
    task automatic pin_write(input bit core, input int pin, input bit dir, input bit val);
        if (core == 1'b0) begin
            if (dir) begin c0_dir_we[pin] = 1'b1; c0_dir_val[pin] = val; end
            else     begin c0_out_we[pin] = 1'b1; c0_out_val[pin] = val; end
        end else begin
            if (dir) begin c1_dir_we[pin] = 1'b1; c1_dir_val[pin] = val; end
            else     begin c1_out_we[pin] = 1'b1; c1_out_val[pin] = val; end
        end
        @(negedge clk);
        c0_out_we = '0; c0_dir_we = '0; c1_out_we = '0; c1_dir_we = '0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 4; a++) read_sel(a[1:0], "R1 owner reset", 16'h0000);
        check("R1 pad_out reset", pad_out, 32'h0);
        check("R1 pad_oe reset", pad_oe, 32'h0);
    endtask

    task automatic t_lock;
        sel_write(2'd1, 8'h20, 16'h0400);
        read_sel(2'd1, "R4 write while locked ignored", 16'h0000);
        // open lock and write in the same cycle: write still ignored
        wp_we = 1'b1; wp_close = 1'b0;
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_fsel = 8'h20; cfg_wdata = 16'h0400;
        @(negedge clk);
        wp_we = 1'b0; cfg_we = 1'b0; cfg_fsel = '0; cfg_wdata = '0;
        read_sel(2'd1, "R4 write in unlock cycle ignored", 16'h0000);
    endtask

    task automatic t_layout;
        sel_write(2'd1, 8'h20, 16'h0400);           // pin 13 -> core 1
        read_sel(2'd1, "R2 pin13 field bits 11:10", 16'h0400);
        pin_write(1'b1, 13, 1'b0, 1'b1);
        check("R6 owner core1 sets out", {31'h0, pad_out[13]}, 32'h1);
        pin_write(1'b1, 13, 1'b1, 1'b1);
        check("R6 owner core1 sets oe", {31'h0, pad_oe[13]}, 32'h1);
        pin_write(1'b0, 13, 1'b0, 1'b0);
        check("R7 core0 out write ignored", {31'h0, pad_out[13]}, 32'h1);
        pin_write(1'b0, 13, 1'b1, 1'b0);
        check("R7 core0 oe write ignored", {31'h0, pad_oe[13]}, 32'h1);
        c0_out_we[13] = 1'b1; c0_out_val[13] = 1'b1;
        c1_out_we[13] = 1'b1; c1_out_val[13] = 1'b0;
        @(negedge clk);
        c0_out_we = '0; c1_out_we = '0;
        check("R7 simultaneous write owner wins", {31'h0, pad_out[13]}, 32'h0);
        sel_write(2'd3, 8'h80, 16'h4000);           // pin 31 -> core 1
        read_sel(2'd3, "R2 pin31 field bits 15:14", 16'h4000);
        pin_write(1'b1, 31, 1'b0, 1'b1);
        check("R2 pin31 follows core1", pad_out, 32'h8000_0000);
    endtask

    task automatic t_fields;
        sel_write(2'd1, 8'h01, 16'hFFFF);           // only pin 8 field
        read_sel(2'd1, "R5 only strobed field changes", 16'h0403);
        read_sel(2'd0, "R5 other register untouched", 16'h0000);
        pin_write(1'b1, 8, 1'b0, 1'b1);
        check("R3 code 11 rejects core1", {31'h0, pad_out[8]}, 32'h0);
        pin_write(1'b0, 8, 1'b0, 1'b1);
        check("R3 code 11 acts as core0", {31'h0, pad_out[8]}, 32'h1);
        sel_write(2'd1, 8'h02, 16'h0008);           // pin 9 -> code 10
        read_sel(2'd1, "R3 code 10 stored", 16'h040B);
        pin_write(1'b0, 9, 1'b1, 1'b1);
        check("R3 code 10 acts as core0", {31'h0, pad_oe[9]}, 32'h1);
        pin_write(1'b1, 9, 1'b1, 1'b0);
        check("R3 code 10 rejects core1", {31'h0, pad_oe[9]}, 32'h1);
    endtask

    task automatic t_switch;
        // pin 20 -> core 1 with a core-1 write in the same cycle
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_fsel = 8'h10; cfg_wdata = 16'h0100;
        c1_out_we[20] = 1'b1; c1_out_val[20] = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_fsel = '0; cfg_wdata = '0; c1_out_we = '0;
        check("R8 same-cycle write uses old owner", {31'h0, pad_out[20]}, 32'h0);
        read_sel(2'd2, "R8 owner field updated", 16'h0100);
        pin_write(1'b1, 20, 1'b0, 1'b1);
        check("R8 new owner active next cycle", {31'h0, pad_out[20]}, 32'h1);
        // back to core 0 with a core-0 write in the same cycle
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_fsel = 8'h10; cfg_wdata = 16'h0000;
        c0_out_we[20] = 1'b1; c0_out_val[20] = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; cfg_fsel = '0; c0_out_we = '0;
        check("R8 core0 write before takeover ignored", {31'h0, pad_out[20]}, 32'h1);
        pin_write(1'b0, 20, 1'b0, 1'b0);
        check("R8 core0 owns after takeover", {31'h0, pad_out[20]}, 32'h0);
    endtask

    task automatic t_relock;
        set_lock(1'b1);
        sel_write(2'd1, 8'hFF, 16'h0000);
        read_sel(2'd1, "R4 write after relock ignored", 16'h040B);
    endtask

    task automatic t_inputs;
        logic [31:0] pats [3] = '{32'hA5A5_0F0F, 32'h0000_0000, 32'hFFFF_FFFF};
        for (int k = 0; k < 3; k++) begin
            pad_in = pats[k];
            #1;
            check("R9 core0 sees pad input", c0_in, pats[k]);
            check("R9 core1 sees pad input", c1_in, pats[k]);
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lock();
        t_layout();
        t_fields();
        t_switch();
        t_relock();
        t_inputs();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule